// File: doc/BRIEF.md
# Peripheral Clock Source Divider Mux

This block produces six peripheral clock-enable strobes from one system clock domain. Every output chooses its input from a set of eight candidates: "off", an auxiliary PLL strobe, or one of six frequency-generator strobes. It then divides the rate of the chosen strobe by a small factor. The factor comes from a 2-bit code that is looked up in a table, and the contents of that table depend on a variant strap.

All six outputs are configured through one 32-bit control register on a simple write/read bus. Per-output disable and enable requests force an output off and bring it back later. While an output is off, the block remembers the last non-zero source it used, and an enable restores that source.

A change to an output's configuration restarts that output's post-divide count. The first strobe after the change therefore arrives one full new period later.

Top module: `pclk_srcmux`

## Requirements
- R1: Output i (0..5) is controlled by register bits [5i+4:5i+2] (source select) and [5i+1:5i] (divide code). Reading returns the register, with bits 31:30 always reading zero.
- R2: A source select of 0 disables the output, so it produces no strobes. Status bit `out_on[i]` reads 1 exactly when the select of output i is nonzero.
- R3: Select 1 routes `pll_stb`. Selects 2 to 7 route `fg_stb[0]` to `fg_stb[5]`. No other input affects the output.
- R4: With `ext_mode` low, divide codes 0, 1, 2 and 3 divide the selected strobe by 1, 4, 1 and 2.
- R5: With `ext_mode` high, divide code 2 divides by 3. The other codes are unchanged.
- R6: An output strobe is asserted in the cycle after the d-th accepted input strobe. Any change of an output's 5-bit field clears its count and suppresses its strobe for that cycle, so the first strobe comes d accepted input strobes after the change.
- R7: A disable request clears the select of that output and leaves its divide code unchanged. An enable request writes back the last nonzero select seen for that output.
- R8: During reset the register loads `boot_cfg[29:0]`. An output whose loaded select is 0 starts disabled, with PLL (select 1) as its remembered source.
- R9: For one output in one cycle, a disable request wins over an enable request, and an enable request wins over a bus write. A field taken by a request ignores the bus write, while the other fields still take it. A written select of 0 leaves the remembered source unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_mode | input | 1 | Variant strap: selects the extended divide table |
| boot_cfg | input | 32 | Control register value loaded during reset |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data |
| pll_stb | input | 1 | Auxiliary PLL clock-enable strobe |
| fg_stb | input | 6 | Frequency-generator clock-enable strobes |
| dis_req | input | 6 | Per-output disable request |
| en_req | input | 6 | Per-output enable request |
| out_stb | output | 6 | Divided peripheral clock-enable strobes |
| out_on | output | 6 | Per-output enabled status |

## Verification
A wrong remembered source stays invisible until the next enable request. It then shows in the read-back select field one cycle later. For that reason the tests always follow a disable with an enable and read the register back.

A post-divide counter that is stale or not cleared shows up as a first strobe arriving earlier or later than d input strobes after a change. A wrong table entry shows up as a pulse count over a fixed window that differs from window/d. The tests measure both the position of the first strobe and the count over the window.

A mis-decoded select appears at once as strobes from an input that should be idle.

// File: rtl/pclk_srcmux.sv
module pclk_srcmux #(
  parameter int N_OUT = 6,
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_mode,
  input  logic [REG_W-1:0] boot_cfg,
  input  logic             bus_we,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             pll_stb,
  input  logic [5:0]       fg_stb,
  input  logic [N_OUT-1:0] dis_req,
  input  logic [N_OUT-1:0] en_req,
  output logic [N_OUT-1:0] out_stb,
  output logic [N_OUT-1:0] out_on
);
  localparam int FW   = 5;
  localparam int USED = FW * N_OUT;

  logic [USED-1:0]       ctl, ctl_n;
  logic [N_OUT-1:0][2:0] rem, rem_n;
  logic [7:0]            srcv;
  logic                  unused_hi;

  assign srcv      = {fg_stb, pll_stb, 1'b0};
  assign bus_rdata = REG_W'(ctl);
  assign unused_hi = ^{bus_wdata[REG_W-1:USED], boot_cfg[REG_W-1:USED]};

  always_comb begin
    ctl_n = ctl;
    rem_n = rem;
    for (int i = 0; i < N_OUT; i++) begin
      if (dis_req[i])
        ctl_n[FW*i+2 +: 3] = 3'd0;
      else if (en_req[i])
        ctl_n[FW*i+2 +: 3] = rem[i];
      else if (bus_we) begin
        ctl_n[FW*i +: FW] = bus_wdata[FW*i +: FW];
        if (bus_wdata[FW*i+2 +: 3] != 3'd0)
          rem_n[i] = bus_wdata[FW*i+2 +: 3];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl <= boot_cfg[USED-1:0];
      for (int i = 0; i < N_OUT; i++)
        rem[i] <= (boot_cfg[FW*i+2 +: 3] != 3'd0) ? boot_cfg[FW*i+2 +: 3] : 3'd1;
    end else begin
      ctl <= ctl_n;
      rem <= rem_n;
    end
  end

  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    logic [2:0] sel;
    logic [1:0] code, lim, cnt;
    logic       hit, fchg, o_q;

    assign sel  = ctl[FW*g+2 +: 3];
    assign code = ctl[FW*g +: 2];
    assign hit  = srcv[sel];
    assign fchg = ctl_n[FW*g +: FW] != ctl[FW*g +: FW];

    always_comb begin
      case (code)
        2'd0: lim = 2'd0;
        2'd1: lim = 2'd3;
        2'd2: lim = ext_mode ? 2'd2 : 2'd0;
        default: lim = 2'd1;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rst_n || fchg) begin
        cnt <= 2'd0;
        o_q <= 1'b0;
      end else if (hit) begin
        if (cnt >= lim) begin
          cnt <= 2'd0;
          o_q <= 1'b1;
        end else begin
          cnt <= cnt + 2'd1;
          o_q <= 1'b0;
        end
      end else
        o_q <= 1'b0;
    end

    assign out_stb[g] = o_q;
    assign out_on[g]  = sel != 3'd0;
  end
endmodule

// File: rtl/pclk_srcmux_chk.sv
module pclk_srcmux_chk #(
  parameter int N_OUT = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic [5*N_OUT-1:0] fld,
  input logic [N_OUT-1:0]   out_stb,
  input logic [N_OUT-1:0]   out_on,
  input logic [N_OUT-1:0]   dis_req,
  input logic [N_OUT-1:0]   en_req
);
  for (genvar g = 0; g < N_OUT; g++) begin : g_chk
    p_off_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (fld[5*g+2 +: 3] == 3'd0) |=> !out_stb[g]);
    p_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_on[g] == (fld[5*g+2 +: 3] != 3'd0));
    p_dis_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dis_req[g] |=> (fld[5*g+2 +: 3] == 3'd0));
    p_en_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (en_req[g] && !dis_req[g]) |=> (fld[5*g+2 +: 3] != 3'd0));
    p_req_code_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (dis_req[g] || en_req[g]) |=> $stable(fld[5*g +: 2]));
    p_change_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(fld[5*g +: 5]) |-> !out_stb[g]);
  end
endmodule

bind pclk_srcmux pclk_srcmux_chk #(.N_OUT(N_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .fld(ctl), .out_stb(out_stb), .out_on(out_on),
  .dis_req(dis_req), .en_req(en_req)
);

// File: tb/pclk_srcmux_bench.sv
module pclk_srcmux_bench;
  logic        clk = 0, rst_n = 0, ext_mode = 0, bus_we = 0, pll_stb = 0;
  logic [31:0] boot_cfg = 0, bus_wdata = 0, bus_rdata;
  logic [5:0]  fg_stb = 0, dis_req = 0, en_req = 0, out_stb, out_on;
  int n_chk = 0, n_bad = 0;

  pclk_srcmux u_pclk_srcmux (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .boot_cfg(boot_cfg),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pll_stb(pll_stb), .fg_stb(fg_stb), .dis_req(dis_req), .en_req(en_req),
    .out_stb(out_stb), .out_on(out_on)
  );

  always #5 clk = ~clk;

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] fld(int i, int sel, int code);
    return 32'((sel * 4 + code) << (5 * i));
  endfunction

  task automatic wr(logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic pulse(bit dis, int i);
    @(negedge clk);
    if (dis) dis_req[i] = 1; else en_req[i] = 1;
    @(negedge clk); dis_req = 0; en_req = 0;
  endtask

  task automatic count(int i, int n, output int cnt, output int first);
    cnt = 0; first = 0;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (out_stb[i]) begin
        cnt++;
        if (first == 0) first = k;
      end
    end
  endtask

  task automatic t_reset();
    boot_cfg = fld(0, 3, 1) | fld(2, 0, 3) | 32'hC000_0000;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R8 reset load", bus_rdata, fld(0, 3, 1) | fld(2, 0, 3));
    chk("R2 status after reset", 32'(out_on), 32'h01);
    chk("R2 no strobes after reset", 32'(out_stb), 32'h0);
    pulse(0, 2);
    chk("R8 default PLL on enable", 32'(bus_rdata[14:10]), 32'h7);
  endtask

  task automatic t_disable_restore();
    pulse(1, 0);
    chk("R7 disable clears select keeps code", 32'(bus_rdata[4:0]), 32'h01);
    chk("R2 status off", 32'(out_on[0]), 32'h0);
    pulse(0, 0);
    chk("R7 enable restores select", 32'(bus_rdata[4:0]), 32'h0D);
  endtask

  task automatic t_table();
    int c, f;
    int dv[4] = '{1, 4, 1, 2};
    pll_stb = 1; fg_stb = 0;
    for (int code = 0; code < 4; code++) begin
      wr(fld(0, 1, code));
      count(0, 36, c, f);
      chk($sformatf("R4 count code %0d", code), 32'(c), 32'(36 / dv[code]));
      chk($sformatf("R6 first strobe code %0d", code), 32'(f), 32'(dv[code]));
    end
    ext_mode = 1;
    wr(fld(0, 1, 2));
    count(0, 36, c, f);
    chk("R5 ext code 2 count", 32'(c), 32'd12);
    chk("R6 ext first strobe", 32'(f), 32'd3);
    wr(fld(0, 1, 1));
    count(0, 36, c, f);
    chk("R5 ext code 1 count", 32'(c), 32'd9);
    ext_mode = 0;
  endtask

  task automatic t_sources();
    int c, f;
    pll_stb = 0;
    for (int k = 0; k < 6; k++) begin
      fg_stb = 6'(1 << k);
      wr(fld(1, k + 2, 3));
      count(1, 20, c, f);
      chk($sformatf("R3 generator %0d routed", k), 32'(c), 32'd10);
      wr(fld(1, ((k + 1) % 6) + 2, 3));
      count(1, 20, c, f);
      chk($sformatf("R3 idle generator beside %0d", k), 32'(c), 32'd0);
    end
    fg_stb = 6'h3F;
    wr(fld(1, 1, 0));
    count(1, 20, c, f);
    chk("R3 PLL select ignores generators", 32'(c), 32'd0);
    fg_stb = 0;
  endtask

  task automatic t_off();
    int c, f;
    pll_stb = 1; fg_stb = 6'h3F;
    wr(fld(3, 0, 0));
    count(3, 20, c, f);
    chk("R2 off output silent", 32'(c), 32'd0);
    chk("R2 off status", 32'(out_on[3]), 32'h0);
    pll_stb = 0; fg_stb = 0;
  endtask

  task automatic t_priority();
    wr(fld(4, 5, 2));
    @(negedge clk);
    dis_req[4] = 1; en_req[4] = 1; bus_we = 1;
    bus_wdata = fld(4, 6, 0) | fld(5, 2, 1);
    @(negedge clk);
    dis_req = 0; en_req = 0; bus_we = 0;
    chk("R9 disable wins field 4", 32'(bus_rdata[24:20]), 32'h02);
    chk("R9 write reaches field 5", 32'(bus_rdata[29:25]), 32'h09);
    @(negedge clk);
    en_req[4] = 1; bus_we = 1; bus_wdata = fld(4, 7, 0);
    @(negedge clk);
    en_req = 0; bus_we = 0;
    chk("R9 enable wins over write", 32'(bus_rdata[24:20]), 32'h16);
    wr(fld(4, 0, 3));
    pulse(0, 4);
    chk("R9 zero write keeps memory", 32'(bus_rdata[24:20]), 32'h17);
  endtask

  task automatic t_layout();
    wr(32'hFFFF_FFFF);
    chk("R1 top bits read zero", bus_rdata, 32'h3FFF_FFFF);
    wr(fld(5, 4, 2));
    chk("R1 field 5 position", bus_rdata, 32'h2400_0000);
    chk("R1 status only output 5", 32'(out_on), 32'h20);
  endtask

  initial begin
    t_reset();
    t_disable_restore();
    t_table();
    t_sources();
    t_off();
    t_priority();
    t_layout();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule